// File: doc/BRIEF.md
# Trap Vector CSR Legalizer

This block holds the trap-vector configuration register of a processor core. The register has two fields: a base address in the upper bits and a two-bit mode in bits [1:0]. It takes write, set-bits and clear-bits accesses from the CSR path. Every result goes through the same legalization step before it is stored, so the stored value, and every read of it, is always legal. The alignment that legalization enforces depends on the mode. Direct mode needs only word alignment. Vectored mode needs alignment to `1 << VEC_ALIGN_BITS` bytes, which is 256 bytes by default.

From the stored value and the trap that is being taken, the block also produces the trap entry PC. That PC is the base, or the base plus four times the cause when the trap is an interrupt in Vectored mode. A single parameterised instance serves either privilege level's copy. A parameter can also turn the register into a fixed, read-only value.

All pins are plain control and data wires. No stream interface is involved, so there is no back-pressure: an access is accepted in any cycle in which `acc_valid_i` is high.

Top module: `trapvec_csr`

## Requirements
- R1: After reset the register reads 0, which is base 0 in Direct mode.
- R2: Mode encoding in bits [1:0] is 2'b00 for Direct and 2'b01 for Vectored. A write selecting Direct stores the operand with bits [1:0] forced to 2'b00, and leaves the base bits [XLEN-1:2] unchanged.
- R3: Whenever the stored mode is Vectored, bits [VEC_ALIGN_BITS-1:2] of the register read as zero (bits [7:2] by default).
- R4: An access whose result carries a reserved mode (2'b10 or 2'b11) keeps the previous mode. Its base bits are still legalized for that kept mode.
- R5: A set access (acc_op_i = 2'b10) stores the legalized value of old OR operand. Setting bit 0 while in Direct mode switches to Vectored and clears bits [7:2].
- R6: A clear access (acc_op_i = 2'b11) stores the legalized value of old AND NOT operand.
- R7: A cycle with acc_valid_i low, or a read-only access (acc_op_i = 2'b00), leaves the register unchanged. A write access uses acc_op_i = 2'b01.
- R8: acc_rdata_o shows the old value in the cycle of an access. The updated value appears from the next cycle on.
- R9: In Direct mode trap_pc_o equals the base (the register with bits [1:0] zeroed) for both interrupts and exceptions.
- R10: In Vectored mode trap_pc_o equals base + 4 × trap_cause_i for an interrupt (trap_irq_i = 1), and equals the base for an exception.
- R11: With READ_ONLY = 1 the register always holds the legalized FIXED_VALUE, and accesses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | CSR access present this cycle |
| acc_op_i | input | 2 | 00 read, 01 write, 10 set bits, 11 clear bits |
| acc_wdata_i | input | XLEN | Access operand |
| acc_rdata_o | output | XLEN | Current (legal) register value |
| trap_irq_i | input | 1 | Trap being taken is an interrupt |
| trap_cause_i | input | CAUSE_W | Trap cause code |
| trap_pc_o | output | XLEN | Trap entry PC |

## Verification
Two things can land in the same clock cycle: an access that rewrites the register, and a trap whose entry PC has to be computed. The bench sets this up by leaving the register in Vectored mode and then, in one cycle, driving a write that switches it to Direct together with an interrupt cause. It checks that trap_pc_o before the edge still uses the old vectored base and cause offset. It then checks that after the edge both the read data and the trap PC reflect the new Direct base.

// File: rtl/trapvec_pkg.sv
package trapvec_pkg;

  localparam logic [1:0] MODE_DIRECT   = 2'b00;
  localparam logic [1:0] MODE_VECTORED = 2'b01;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_SET   = 2'b10,
    ACC_CLEAR = 2'b11
  } acc_op_e;

  function automatic logic mode_is_legal(input logic [1:0] m);
    return (m == MODE_DIRECT) || (m == MODE_VECTORED);
  endfunction

endpackage

// File: rtl/trapvec_rmw.sv
module trapvec_rmw
  import trapvec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            valid_i,
  input  logic [1:0]      op_i,
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] opnd_i,
  output logic [XLEN-1:0] raw_o,
  output logic            upd_o
);

  acc_op_e op;
  assign op = acc_op_e'(op_i);

  always_comb begin
    raw_o = old_i;
    upd_o = 1'b0;
    if (valid_i) begin
      unique case (op)
        ACC_WRITE: begin raw_o = opnd_i;           upd_o = 1'b1; end
        ACC_SET:   begin raw_o = old_i | opnd_i;   upd_o = 1'b1; end
        ACC_CLEAR: begin raw_o = old_i & ~opnd_i;  upd_o = 1'b1; end
        default:   begin raw_o = old_i;            upd_o = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/trapvec_legal.sv
module trapvec_legal
  import trapvec_pkg::*;
#(
  parameter int XLEN           = 32,
  parameter int VEC_ALIGN_BITS = 8
) (
  input  logic [XLEN-1:0] raw_i,
  input  logic [1:0]      old_mode_i,
  output logic [XLEN-1:0] legal_o
);

  localparam logic [XLEN-1:0] ONE      = 1;
  localparam logic [XLEN-1:0] WORD_MSK = ~((ONE << 2) - ONE);
  localparam logic [XLEN-1:0] VEC_MSK  = ~((ONE << VEC_ALIGN_BITS) - ONE);

  logic [1:0]      mode_n;
  logic [XLEN-1:0] base_n;

  always_comb begin
    mode_n  = mode_is_legal(raw_i[1:0]) ? raw_i[1:0] : old_mode_i;
    base_n  = (mode_n == MODE_VECTORED) ? (raw_i & VEC_MSK) : (raw_i & WORD_MSK);
    legal_o = base_n | {{(XLEN-2){1'b0}}, mode_n};
  end

endmodule

// File: rtl/trapvec_target.sv
module trapvec_target
  import trapvec_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic [XLEN-1:0]    csr_i,
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [XLEN-1:0]    pc_o
);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offs;

  always_comb begin
    base = {csr_i[XLEN-1:2], 2'b00};
    offs = {{(XLEN-CAUSE_W){1'b0}}, cause_i} << 2;
    pc_o = (csr_i[1:0] == MODE_VECTORED && irq_i) ? base + offs : base;
  end

endmodule

// File: rtl/trapvec_csr.sv
module trapvec_csr
  import trapvec_pkg::*;
#(
  parameter int              XLEN           = 32,
  parameter int              VEC_ALIGN_BITS = 8,
  parameter int              CAUSE_W        = 6,
  parameter bit              READ_ONLY      = 1'b0,
  parameter logic [XLEN-1:0] FIXED_VALUE    = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic [1:0]         acc_op_i,
  input  logic [XLEN-1:0]    acc_wdata_i,
  output logic [XLEN-1:0]    acc_rdata_o,
  input  logic               trap_irq_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  output logic [XLEN-1:0]    trap_pc_o
);

  logic [XLEN-1:0] csr_q;

  generate
    if (READ_ONLY) begin : g_fixed
      logic [XLEN-1:0] fixed_legal;
      trapvec_legal #(.XLEN(XLEN), .VEC_ALIGN_BITS(VEC_ALIGN_BITS)) u_fix (
        .raw_i(FIXED_VALUE), .old_mode_i(MODE_DIRECT), .legal_o(fixed_legal)
      );
      assign csr_q = fixed_legal;

      p_ro_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_valid_i |=> $stable(acc_rdata_o));
    end else begin : g_rw
      logic [XLEN-1:0] raw;
      logic [XLEN-1:0] legal;
      logic            upd;
      logic [XLEN-1:0] store_q;

      trapvec_rmw #(.XLEN(XLEN)) u_rmw (
        .valid_i(acc_valid_i), .op_i(acc_op_i), .old_i(store_q),
        .opnd_i(acc_wdata_i), .raw_o(raw), .upd_o(upd)
      );

      trapvec_legal #(.XLEN(XLEN), .VEC_ALIGN_BITS(VEC_ALIGN_BITS)) u_leg (
        .raw_i(raw), .old_mode_i(store_q[1:0]), .legal_o(legal)
      );

      always_ff @(posedge clk_i) begin
        if (!rst_ni)  store_q <= '0;
        else if (upd) store_q <= legal;
      end
      assign csr_q = store_q;

      p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!acc_valid_i || acc_op_i == ACC_READ) |=> $stable(store_q));
      p_set_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && acc_op_i == ACC_SET && acc_wdata_i[XLEN-1:VEC_ALIGN_BITS] == '0)
        |=> store_q[XLEN-1:VEC_ALIGN_BITS] == $past(store_q[XLEN-1:VEC_ALIGN_BITS]));
    end
  endgenerate

  assign acc_rdata_o = csr_q;

  trapvec_target #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_tgt (
    .csr_i(csr_q), .irq_i(trap_irq_i), .cause_i(trap_cause_i), .pc_o(trap_pc_o)
  );

  p_vec_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rdata_o[1:0] == MODE_VECTORED) |-> (acc_rdata_o[VEC_ALIGN_BITS-1:2] == '0));
  p_mode_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rdata_o[1] == 1'b0);
  p_exc_base_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_irq_i |-> trap_pc_o == {acc_rdata_o[XLEN-1:2], 2'b00});
  p_direct_base_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rdata_o[1:0] == MODE_DIRECT) |-> trap_pc_o == {acc_rdata_o[XLEN-1:2], 2'b00});

endmodule

// File: tb/trapvec_csr_test.sv
`timescale 1ns/1ps
module trapvec_csr_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] wd = '0;
  logic        irq = 1'b0;
  logic [5:0]  cause = '0;
  logic [31:0] rd, pc, rd_ro, pc_ro;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  trapvec_csr uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(vld), .acc_op_i(op),
    .acc_wdata_i(wd), .acc_rdata_o(rd), .trap_irq_i(irq),
    .trap_cause_i(cause), .trap_pc_o(pc)
  );

  trapvec_csr #(.READ_ONLY(1'b1), .FIXED_VALUE(32'h0000_41FD)) uut_ro (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(vld), .acc_op_i(op),
    .acc_wdata_i(wd), .acc_rdata_o(rd_ro), .trap_irq_i(irq),
    .trap_cause_i(cause), .trap_pc_o(pc_ro)
  );

  typedef struct packed {
    logic        v;
    logic [1:0]  o;
    logic [31:0] d;
    logic [31:0] e;
  } step_t;

  localparam int NSTEP = 14;
  localparam step_t TAB [NSTEP] = '{
    '{1'b1, 2'd1, 32'h8000_1234, 32'h8000_1234},  // R2 direct write
    '{1'b1, 2'd2, 32'h0000_0001, 32'h8000_1201},  // R5 set bit0 -> vectored, R3 align
    '{1'b1, 2'd3, 32'h0000_0001, 32'h8000_1200},  // R6 clear bit0 -> direct
    '{1'b1, 2'd2, 32'h0000_0001, 32'h8000_1201},  // R5
    '{1'b1, 2'd1, 32'h0000_0402, 32'h0000_0401},  // R4 reserved 10 keeps vectored
    '{1'b1, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FF01},  // R4 reserved 11, R3
    '{1'b1, 2'd3, 32'hFFFF_0000, 32'h0000_FF01},  // R6
    '{1'b1, 2'd0, 32'h0000_AAAA, 32'h0000_FF01},  // R7 read op
    '{1'b1, 2'd3, 32'h0000_0001, 32'h0000_FF00},  // R6
    '{1'b1, 2'd1, 32'h1234_567D, 32'h1234_5601},  // R3 vectored write
    '{1'b1, 2'd1, 32'h1234_567C, 32'h1234_567C},  // R2
    '{1'b1, 2'd2, 32'h0000_0003, 32'h1234_567C},  // R4 set to reserved keeps direct
    '{1'b1, 2'd1, 32'h0000_0FFE, 32'h0000_0FFC},  // R4
    '{1'b0, 2'd1, 32'h0000_DEAD, 32'h0000_0FFC}   // R7 no valid
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic v, input logic [1:0] o, input logic [31:0] d);
    @(negedge clk);
    vld = v; op = o; wd = d;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev;
    repeat (3) @(negedge clk);
    check("R1 reset read", rd, 32'h0);
    check("R1 reset trap pc", pc, 32'h0);
    rst_n = 1'b1;
    prev = 32'h0;

    for (int i = 0; i < NSTEP; i++) begin
      access(TAB[i].v, TAB[i].o, TAB[i].d);
      #1 check("R8 old value in access cycle", rd, prev);
      @(posedge clk);
      #1 check($sformatf("R2-step %0d table", i), rd, TAB[i].e);
      prev = TAB[i].e;
    end
    vld = 1'b0;

    // Direct mode trap targets
    @(negedge clk);
    irq = 1'b1; cause = 6'd5;
    #1 check("R9 direct irq", pc, 32'h0000_0FFC);
    irq = 1'b0;
    #1 check("R9 direct exception", pc, 32'h0000_0FFC);

    // Vectored trap targets
    access(1'b1, 2'd1, 32'h0000_2001);
    @(negedge clk); vld = 1'b0;
    check("R3 vectored base", rd, 32'h0000_2001);
    irq = 1'b1; cause = 6'd5;
    #1 check("R10 vectored irq cause 5", pc, 32'h0000_2014);
    cause = 6'd63;
    #1 check("R10 vectored irq cause 63", pc, 32'h0000_20FC);
    irq = 1'b0; cause = 6'd5;
    #1 check("R10 vectored exception", pc, 32'h0000_2000);

    // Same-cycle update and trap
    access(1'b1, 2'd1, 32'h0000_3000);
    irq = 1'b1; cause = 6'd3;
    #1 check("R8 trap uses old vectored value", pc, 32'h0000_200C);
    @(posedge clk);
    #1 check("R8 new value after edge", rd, 32'h0000_3000);
    check("R9 trap after switch to direct", pc, 32'h0000_3000);
    vld = 1'b0;

    // Read-only instance
    check("R11 fixed value legalized", rd_ro, 32'h0000_4101);
    check("R11 fixed irq target", pc_ro, 32'h0000_410C);

    // Reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset after use", rd, 32'h0);
    check("R11 fixed value after writes", rd_ro, 32'h0000_4101);
    rst_n = 1'b1; irq = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule